// File: doc/BRIEF.md
# Display Port and Run-Control Register Block

This block sits on a processor's 16-bit memory bus and gives software three registers: a display status word, a display data word and a machine control word. To print a character, a program polls the status word until its top bit is set, then writes the character to the data word. The block passes the low byte of that write to a character sink over a valid/ready handshake. The ready bit stays low until the sink takes the character.

The control word holds a run latch in its top bit. The block drives this latch out as the processor's clock enable. When software writes the control word with the top bit cleared, the clock enable drops on the next cycle. The write therefore completes before the processor stops. Writing the bit back to one starts it again.

Reads have no side effects. Reads of unmapped addresses, and all bus cycles that are not reads, return zero on the read data port. The register locations are parameters, with defaults of 0xFE04 for status, 0xFE06 for data and 0xFFFE for control.

Top module: `dispctl_top`

## Requirements
- R1: After reset, the status word and the control word both read 0x8000, `run_en` is 1 and `chr_valid` is 0. Reset also drops a pending character and sets the run latch again.
- R2: The status word reads bit 15 = 1 exactly when no character is waiting in the sink handshake. Its bits 14:0 read 0.
- R3: A data-word write while bit 15 of status is 1 raises `chr_valid` from the next cycle on, with `chr_data` equal to bits 7:0 of the written word. Status bit 15 then reads 0.
- R4: While `chr_valid` is 1 and `chr_ready` is 0, `chr_valid` and `chr_data` stay unchanged. In the cycle after `chr_valid` and `chr_ready` are both 1, `chr_valid` is 0 and status bit 15 reads 1.
- R5: A data-word write while a character is pending is dropped. `chr_data` keeps the pending character and only that character is delivered.
- R6: A control-word write loads the run latch from bit 15 of the written word. `run_en` follows from the next cycle. The control word reads the latch in bit 15 and 0 in bits 14:0.
- R7: Writes to the status word change no state. A later status read returns the same value as before the write.
- R8: A bus cycle to any address other than the three register addresses gives `bus_hit` = 0 and `bus_rdata` = 0 and changes no state. With `bus_valid` = 0, `bus_rdata` is 0.
- R9: A data-word read returns the last accepted character zero-extended to 16 bits. This is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address of the bus cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, 0 when not a mapped read |
| bus_hit | output | 1 | Address matches one of the three registers |
| chr_valid | output | 1 | A character is offered to the sink |
| chr_data | output | 8 | Offered character |
| chr_ready | input | 1 | Sink takes the character when chr_valid is 1 |
| run_en | output | 1 | Processor clock enable (run latch) |

## Verification
A stuck or wrong pending flag shows up within one bus cycle. Either the status word's sign bit disagrees with `chr_valid`, or a second write overwrites the offered byte, and both are visible on the next read or edge. A run latch that loads at the wrong time shows as `run_en` changing in the write cycle itself or not changing one cycle later. A decode fault shows as a nonzero read or a set `bus_hit` on a neighbouring address in the same cycle.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

    localparam int NUM_REGS = 3;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_DATA   = 2'd1,
        REG_CTRL   = 2'd2
    } reg_idx_e;

    typedef struct packed {
        logic ctrl;
        logic data;
        logic status;
    } reg_sel_t;

    typedef struct packed {
        logic rd;
        logic wr;
    } bus_op_t;

endpackage

// File: rtl/dispctl_decode.sv
module dispctl_decode
    import dispctl_pkg::*;
#(
    parameter int           ADDR_W    = 16,
    parameter logic [15:0]  STAT_ADDR = 16'hFE04,
    parameter logic [15:0]  DOUT_ADDR = 16'hFE06,
    parameter logic [15:0]  CTRL_ADDR = 16'hFFFE
) (
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_t          sel,
    output bus_op_t           op
);

    localparam logic [ADDR_W-1:0] MAP [NUM_REGS] = '{
        STAT_ADDR[ADDR_W-1:0],
        DOUT_ADDR[ADDR_W-1:0],
        CTRL_ADDR[ADDR_W-1:0]
    };

    logic [NUM_REGS-1:0] match;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
        assign match[g] = bus_valid && (bus_addr == MAP[g]);
    end

    always_comb begin
        sel.status = match[REG_STATUS];
        sel.data   = match[REG_DATA];
        sel.ctrl   = match[REG_CTRL];
        op.wr      = bus_valid &&  bus_we;
        op.rd      = bus_valid && !bus_we;
    end

endmodule

// File: rtl/dispctl_chan.sv
module dispctl_chan #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_char,
    input  logic [CHAR_W-1:0] wr_byte,
    input  logic              chr_ready,
    output logic              chr_valid,
    output logic [CHAR_W-1:0] chr_data,
    output logic              idle
);

    typedef struct packed {
        logic              pending;
        logic [CHAR_W-1:0] chr;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     accept, handoff;

    always_comb begin
        st_d    = st_q;
        handoff = st_q.pending && chr_ready;
        accept  = wr_char && !st_q.pending;
        if (handoff) begin
            st_d.pending = 1'b0;
        end
        if (accept) begin
            st_d.pending = 1'b1;
            st_d.chr     = wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chr_valid = st_q.pending;
    assign chr_data  = st_q.chr;
    assign idle      = !st_q.pending;

endmodule

// File: rtl/dispctl_runctl.sv
module dispctl_runctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic run_bit,
    output logic run
);

    typedef struct packed {
        logic run;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.run = run_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.run <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign run = st_q.run;

endmodule

// File: rtl/dispctl_rdmux.sv
module dispctl_rdmux
    import dispctl_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CHAR_W    = 8,
    parameter int READY_BIT = 15,
    parameter int RUN_BIT   = 15
) (
    input  reg_sel_t          sel,
    input  bus_op_t           op,
    input  logic              idle,
    input  logic [CHAR_W-1:0] last_chr,
    input  logic              run,
    output logic [DATA_W-1:0] rdata,
    output logic              hit
);

    always_comb begin
        rdata = '0;
        if (op.rd) begin
            if (sel.status) begin
                rdata[READY_BIT] = idle;
            end else if (sel.data) begin
                rdata[CHAR_W-1:0] = last_chr;
            end else if (sel.ctrl) begin
                rdata[RUN_BIT] = run;
            end
        end
        hit = sel.status || sel.data || sel.ctrl;
    end

endmodule

// File: rtl/dispctl_top.sv
module dispctl_top
    import dispctl_pkg::*;
#(
    parameter int           ADDR_W    = 16,
    parameter int           DATA_W    = 16,
    parameter int           CHAR_W    = 8,
    parameter int           READY_BIT = 15,
    parameter int           RUN_BIT   = 15,
    parameter logic [15:0]  STAT_ADDR = 16'hFE04,
    parameter logic [15:0]  DOUT_ADDR = 16'hFE06,
    parameter logic [15:0]  CTRL_ADDR = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_hit,
    output logic              chr_valid,
    output logic [CHAR_W-1:0] chr_data,
    input  logic              chr_ready,
    output logic              run_en
);

    reg_sel_t sel;
    bus_op_t  op;
    logic     idle;
    logic     run;

    dispctl_decode #(
        .ADDR_W   (ADDR_W),
        .STAT_ADDR(STAT_ADDR),
        .DOUT_ADDR(DOUT_ADDR),
        .CTRL_ADDR(CTRL_ADDR)
    ) decode_i (
        .bus_valid(bus_valid),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .sel      (sel),
        .op       (op)
    );

    dispctl_chan #(
        .CHAR_W(CHAR_W)
    ) chan_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_char  (op.wr && sel.data),
        .wr_byte  (bus_wdata[CHAR_W-1:0]),
        .chr_ready(chr_ready),
        .chr_valid(chr_valid),
        .chr_data (chr_data),
        .idle     (idle)
    );

    dispctl_runctl runctl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctrl(op.wr && sel.ctrl),
        .run_bit(bus_wdata[RUN_BIT]),
        .run    (run)
    );

    dispctl_rdmux #(
        .DATA_W   (DATA_W),
        .CHAR_W   (CHAR_W),
        .READY_BIT(READY_BIT),
        .RUN_BIT  (RUN_BIT)
    ) rdmux_i (
        .sel     (sel),
        .op      (op),
        .idle    (idle),
        .last_chr(chr_data),
        .run     (run),
        .rdata   (bus_rdata),
        .hit     (bus_hit)
    );

    assign run_en = run;

endmodule

// File: rtl/dispctl_checker.sv
module dispctl_checker #(
    parameter int           ADDR_W    = 16,
    parameter int           DATA_W    = 16,
    parameter int           CHAR_W    = 8,
    parameter int           READY_BIT = 15,
    parameter int           RUN_BIT   = 15,
    parameter logic [15:0]  STAT_ADDR = 16'hFE04,
    parameter logic [15:0]  DOUT_ADDR = 16'hFE06,
    parameter logic [15:0]  CTRL_ADDR = 16'hFFFE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_hit,
    input logic              chr_valid,
    input logic [CHAR_W-1:0] chr_data,
    input logic              chr_ready,
    input logic              run_en
);

    logic mapped;
    assign mapped = (bus_addr == STAT_ADDR[ADDR_W-1:0]) ||
                    (bus_addr == DOUT_ADDR[ADDR_W-1:0]) ||
                    (bus_addr == CTRL_ADDR[ADDR_W-1:0]);

    assert_status_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we && bus_addr == STAT_ADDR[ADDR_W-1:0])
        |-> (bus_rdata[READY_BIT] == !chr_valid));

    assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && bus_addr == DOUT_ADDR[ADDR_W-1:0] && !chr_valid)
        |=> (chr_valid && chr_data == $past(bus_wdata[CHAR_W-1:0])));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && !chr_ready) |=> (chr_valid && $stable(chr_data)));

    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && chr_ready) |=> !chr_valid);

    assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && !chr_ready) |=> $stable(chr_data));

    assert_run_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && bus_addr == CTRL_ADDR[ADDR_W-1:0])
        |=> (run_en == $past(bus_wdata[RUN_BIT])));

    assert_run_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_we && bus_addr == CTRL_ADDR[ADDR_W-1:0]) |=> $stable(run_en));

    assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !mapped) |-> (!bus_hit && bus_rdata == '0));

    assert_idle_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (bus_rdata == '0 && !bus_hit));

endmodule

bind dispctl_top dispctl_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CHAR_W   (CHAR_W),
    .READY_BIT(READY_BIT),
    .RUN_BIT  (RUN_BIT),
    .STAT_ADDR(STAT_ADDR),
    .DOUT_ADDR(DOUT_ADDR),
    .CTRL_ADDR(CTRL_ADDR)
) checker_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .bus_hit  (bus_hit),
    .chr_valid(chr_valid),
    .chr_data (chr_data),
    .chr_ready(chr_ready),
    .run_en   (run_en)
);

// File: tb/dispctl_tb.sv
module dispctl_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_hit;
    logic        chr_valid;
    logic [7:0]  chr_data;
    logic        chr_ready = 1'b0;
    logic        run_en;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dispctl_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_valid(bus_valid),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .bus_hit  (bus_hit),
        .chr_valid(chr_valid),
        .chr_data (chr_data),
        .chr_ready(chr_ready),
        .run_en   (run_en)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        we;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic        crdy;
        logic [15:0] exp_rd;
        logic        exp_hit;
        logic        exp_cv;
        logic [7:0]  exp_cd;
        logic        exp_run;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VECS [NVEC] = '{
        '{4'd1, 1'b0, 16'hFE04, 16'h0000, 1'b0, 16'h8000, 1'b1, 1'b0, 8'h00, 1'b1}, // R1
        '{4'd1, 1'b0, 16'hFFFE, 16'h0000, 1'b0, 16'h8000, 1'b1, 1'b0, 8'h00, 1'b1}, // R1
        '{4'd7, 1'b1, 16'hFE04, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 8'h00, 1'b1}, // R7
        '{4'd7, 1'b0, 16'hFE04, 16'h0000, 1'b0, 16'h8000, 1'b1, 1'b0, 8'h00, 1'b1}, // R7
        '{4'd3, 1'b1, 16'hFE06, 16'h1241, 1'b0, 16'h0000, 1'b1, 1'b1, 8'h41, 1'b1}, // R3
        '{4'd3, 1'b0, 16'hFE04, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 8'h41, 1'b1}, // R3
        '{4'd5, 1'b1, 16'hFE06, 16'h0055, 1'b0, 16'h0000, 1'b1, 1'b1, 8'h41, 1'b1}, // R5
        '{4'd9, 1'b0, 16'hFE06, 16'h0000, 1'b0, 16'h0041, 1'b1, 1'b1, 8'h41, 1'b1}, // R9
        '{4'd4, 1'b0, 16'hFE04, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 8'h00, 1'b1}, // R4
        '{4'd2, 1'b0, 16'hFE04, 16'h0000, 1'b0, 16'h8000, 1'b1, 1'b0, 8'h00, 1'b1}, // R2
        '{4'd6, 1'b1, 16'hFFFE, 16'h7FFF, 1'b0, 16'h0000, 1'b1, 1'b0, 8'h00, 1'b0}, // R6
        '{4'd6, 1'b0, 16'hFFFE, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 8'h00, 1'b0}, // R6
        '{4'd6, 1'b1, 16'hFFFE, 16'hFFFF, 1'b0, 16'h0000, 1'b1, 1'b0, 8'h00, 1'b1}, // R6
        '{4'd6, 1'b0, 16'hFFFE, 16'h0000, 1'b0, 16'h8000, 1'b1, 1'b0, 8'h00, 1'b1}, // R6
        '{4'd8, 1'b0, 16'hFE05, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1}, // R8
        '{4'd8, 1'b1, 16'hFFFC, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1}, // R8
        '{4'd3, 1'b1, 16'hFE06, 16'h00C3, 1'b1, 16'h0000, 1'b1, 1'b1, 8'hC3, 1'b1}, // R3
        '{4'd9, 1'b0, 16'hFE06, 16'h0000, 1'b0, 16'h00C3, 1'b1, 1'b1, 8'hC3, 1'b1}, // R9
        '{4'd5, 1'b1, 16'hFE06, 16'h0077, 1'b1, 16'h0000, 1'b1, 1'b0, 8'h00, 1'b1}, // R5
        '{4'd9, 1'b0, 16'hFE06, 16'h0000, 1'b0, 16'h00C3, 1'b1, 1'b0, 8'h00, 1'b1}  // R9
    };

    task automatic check(input int req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic we, input logic [15:0] a,
                         input logic [15:0] d, input logic cr);
        bus_valid = v;
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = d;
        chr_ready = cr;
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL R0 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: outputs straight after reset
        #1;
        check(1, "run_en after reset", {15'd0, run_en}, 16'd1);
        check(1, "chr_valid after reset", {15'd0, chr_valid}, 16'd0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(1'b1, VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].crdy);
            #1;
            check(int'(VECS[i].req), "bus_rdata", bus_rdata, VECS[i].exp_rd);
            check(int'(VECS[i].req), "bus_hit", {15'd0, bus_hit}, {15'd0, VECS[i].exp_hit});
            @(posedge clk);
            #1;
            check(int'(VECS[i].req), "chr_valid", {15'd0, chr_valid}, {15'd0, VECS[i].exp_cv});
            if (VECS[i].exp_cv) begin
                check(int'(VECS[i].req), "chr_data", {8'd0, chr_data}, {8'd0, VECS[i].exp_cd});
            end
            check(int'(VECS[i].req), "run_en", {15'd0, run_en}, {15'd0, VECS[i].exp_run});
        end

        // R8: idle bus returns zero even with a mapped address presented
        @(negedge clk);
        drive(1'b0, 1'b0, 16'hFE04, 16'h0000, 1'b0);
        #1;
        check(8, "idle rdata", bus_rdata, 16'h0000);
        check(8, "idle hit", {15'd0, bus_hit}, 16'd0);

        // R4: character held stable for several cycles while the sink stalls
        @(negedge clk);
        drive(1'b1, 1'b1, 16'hFE06, 16'hAB5A, 1'b0);
        @(negedge clk);
        drive(1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(4, "stall chr_valid", {15'd0, chr_valid}, 16'd1);
            check(4, "stall chr_data", {8'd0, chr_data}, 16'h005A);
        end

        // R1: reset while a character is pending and the run latch is cleared
        drive(1'b1, 1'b1, 16'hFFFE, 16'h0000, 1'b0);
        @(negedge clk);
        drive(1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0);
        check(6, "run_en cleared", {15'd0, run_en}, 16'd0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(1, "run_en after re-reset", {15'd0, run_en}, 16'd1);
        check(1, "chr_valid after re-reset", {15'd0, chr_valid}, 16'd0);
        drive(1'b1, 1'b0, 16'hFE04, 16'h0000, 1'b0);
        #1;
        check(1, "status after re-reset", bus_rdata, 16'h8000);
        drive(1'b1, 1'b0, 16'hFE06, 16'h0000, 1'b0);
        #1;
        check(9, "data after re-reset", bus_rdata, 16'h0000);
        @(negedge clk);
        drive(1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule